// File: doc/BRIEF.md
# Banked Matrix-Vector Multiply Engine

This block computes the product R = C·D of a square signed coefficient matrix and a column vector of signed 12-bit samples. It holds one coefficient set, or bank, per output element. A row of sixteen multiply taps works through the banks in turn, so the taps of a filter datapath yield a whole matrix product one result per cycle. Vector elements arrive one per accepted strobe. Once the last element is in, the engine switches its active bank on every cycle and emits one result per cycle, in ascending index order.

The engine runs either as one 16×16 engine or as two independent 8×8 engines. The split is chosen when the first element of a vector is accepted. In the split configuration, engine A takes its vector from the primary input. Engine B takes its vector from either the secondary input or the primary input, and both engines produce their results in the same cycles. Coefficients are written one at a time through an addressed load port.

Top module: `mvm_engine`

## Requirements
- R1: While reset is held and after it is released, busy, res_valid, res_a and res_b are all 0.
- R2: When dual_mode is 0 at the first element, 16 elements D_0..D_15 are taken from din. Then for j = 0..15, in consecutive cycles, res_valid is 1, res_index = j and res_a = sum over k of C[j][k]·D_k, where C[r][c] is the value last written at coef_row = r, coef_col = c. The result for j = 0 appears in the second cycle after the last element is accepted.
- R3: When dual_mode is 1 at the first element, 8 elements are taken per engine. In eight consecutive cycles, for j = 0..7, res_a = sum over k<8 of C[j][k]·A_k and res_b = sum over k<8 of C[8+j][8+k]·B_k. Both results are presented together, with res_index = j.
- R4: In the dual configuration, B_k comes from rin when b_from_rin = 1 and from din when b_from_rin = 0. A_k always comes from din.
- R5: Products and sums are signed two's complement with no overflow inside the accumulator. Each output is the low 16 bits of the exact sum.
- R6: busy is 1 from the cycle after the last element is accepted until the cycle that presents the final result. vec_valid while busy is 1 is ignored.
- R7: In the single configuration, res_b is 0 whenever res_valid is 1.
- R8: dual_mode and b_from_rin are sampled only with the first element of a vector. Changing them later in that vector has no effect on its element count or its results.
- R9: A coefficient written at a given row and column replaces the old value for all later products.
- R10: Elements need not arrive in consecutive cycles. Cycles with vec_valid = 0 between elements add nothing to the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1 = two 8×8 engines, 0 = one 16×16 engine |
| b_from_rin | input | 1 | In dual configuration, engine B takes rin (1) or din (0) |
| vec_valid | input | 1 | Vector element strobe |
| din | input | 12 | Primary vector element, signed |
| rin | input | 12 | Secondary vector element, signed |
| coef_we | input | 1 | Coefficient write strobe |
| coef_row | input | 4 | Bank (output index) of the coefficient |
| coef_col | input | 4 | Tap (input index) of the coefficient |
| coef_data | input | 12 | Coefficient value, signed |
| busy | output | 1 | Engine is emitting results and accepts no element |
| res_valid | output | 1 | A result is present |
| res_index | output | 4 | Output element index j |
| res_a | output | 16 | Result of the full engine or of engine A |
| res_b | output | 16 | Result of engine B, 0 in single configuration |

## Verification
A wrong element counter shows up as a shifted result sequence, or as busy rising early or late. These errors appear at the ports within one cycle of the last expected element. A wrong bank counter or row offset corrupts the value or index of the very next result. The bench therefore compares busy, res_valid, res_index and both results on every cycle of each run. A stale configuration latch or an accepted busy-time strobe corrupts the following vector, and that vector's first result exposes it.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  typedef enum logic {ST_LOAD, ST_RUN} seq_state_e;
endpackage

// File: rtl/mvm_coef_bank.sv
module mvm_coef_bank #(
  parameter int NMAX = 16,
  parameter int CW   = 12,
  localparam int AW    = $clog2(NMAX),
  localparam int NHALF = NMAX / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_row,
  input  logic [AW-1:0]             wr_col,
  input  logic [CW-1:0]             wr_data,
  input  logic [AW-1:0]             bank,
  input  logic                      dual,
  output logic [NMAX-1:0][CW-1:0]   tap_coef
);
  logic [CW-1:0] mem [NMAX][NMAX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NMAX; r++)
        for (int c = 0; c < NMAX; c++)
          mem[r][c] <= '0;
    end else if (wr_en) begin
      mem[wr_row][wr_col] <= wr_data;
    end
  end

  // Upper taps read banks offset by NHALF when split into two engines
  for (genvar k = 0; k < NMAX; k++) begin : g_tap
    logic [AW-1:0] row;
    if (k >= NHALF) begin : g_hi
      assign row = dual ? (bank + AW'(NHALF)) : bank;
    end else begin : g_lo
      assign row = bank;
    end
    assign tap_coef[k] = mem[row][k];
  end
endmodule

// File: rtl/mvm_tap_array.sv
module mvm_tap_array #(
  parameter int NMAX = 16,
  parameter int CW   = 12,
  parameter int DW   = 12,
  localparam int NHALF = NMAX / 2,
  localparam int ACCW  = CW + DW + $clog2(NMAX)
) (
  input  logic [NMAX-1:0][CW-1:0] tap_coef,
  input  logic [NMAX-1:0][DW-1:0] tap_data,
  output logic signed [ACCW-1:0]  sum_lo,
  output logic signed [ACCW-1:0]  sum_hi
);
  function automatic logic signed [ACCW-1:0] tap_mul(input logic [CW-1:0] c,
                                                     input logic [DW-1:0] d);
    logic signed [ACCW-1:0] cx;
    logic signed [ACCW-1:0] dx;
    cx = ACCW'($signed(c));
    dx = ACCW'($signed(d));
    return cx * dx;
  endfunction

  logic signed [ACCW-1:0] prod [NMAX];

  for (genvar k = 0; k < NMAX; k++) begin : g_mul
    assign prod[k] = tap_mul(tap_coef[k], tap_data[k]);
  end

  always_comb begin
    sum_lo = '0;
    sum_hi = '0;
    for (int k = 0; k < NHALF; k++) begin
      sum_lo = sum_lo + prod[k];
      sum_hi = sum_hi + prod[NHALF + k];
    end
  end
endmodule

// File: rtl/mvm_seq.sv
module mvm_seq
  import mvm_pkg::*;
#(
  parameter int NMAX = 16,
  localparam int AW    = $clog2(NMAX),
  localparam int NHALF = NMAX / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vec_valid,
  input  logic          dual_mode,
  input  logic          b_from_rin,
  output logic          busy,
  output logic          vec_accept,
  output logic [AW-1:0] wr_idx,
  output logic          dual_eff,
  output logic          bsel_eff,
  output logic [AW-1:0] bank,
  output logic          run_step
);
  seq_state_e    state;
  logic [AW-1:0] load_idx;
  logic          dual_q;
  logic          bsel_q;
  logic          fresh;
  logic [AW-1:0] n_last;
  logic          last_elem;
  logic          last_out;

  assign fresh      = (state == ST_LOAD) && (load_idx == '0);
  assign dual_eff   = fresh ? dual_mode  : dual_q;
  assign bsel_eff   = fresh ? b_from_rin : bsel_q;
  assign n_last     = dual_eff ? AW'(NHALF - 1) : AW'(NMAX - 1);
  assign vec_accept = vec_valid && (state == ST_LOAD);
  assign last_elem  = vec_accept && (load_idx == n_last);
  assign run_step   = (state == ST_RUN);
  assign last_out   = run_step && (bank == n_last);
  assign busy       = run_step;
  assign wr_idx     = load_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_LOAD;
      load_idx <= '0;
      bank     <= '0;
      dual_q   <= 1'b0;
      bsel_q   <= 1'b0;
    end else begin
      if (fresh) begin
        dual_q <= dual_mode;
        bsel_q <= b_from_rin;
      end
      if (vec_accept) begin
        load_idx <= last_elem ? '0 : load_idx + 1'b1;
        if (last_elem) begin
          state <= ST_RUN;
          bank  <= '0;
        end
      end
      if (run_step) begin
        bank <= bank + 1'b1;
        if (last_out) state <= ST_LOAD;
      end
    end
  end

  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_step |-> (bank <= (dual_q ? AW'(NHALF - 1) : AW'(NMAX - 1)))); // R3
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fresh && !(state == ST_RUN && last_out)) |=> $stable(dual_q) && $stable(bsel_q)); // R8
  AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |-> (load_idx <= n_last)); // R10
endmodule

// File: rtl/mvm_engine.sv
module mvm_engine #(
  parameter int NMAX = 16,
  parameter int CW   = 12,
  parameter int DW   = 12,
  parameter int OW   = 16,
  localparam int AW    = $clog2(NMAX),
  localparam int NHALF = NMAX / 2,
  localparam int ACCW  = CW + DW + $clog2(NMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual_mode,
  input  logic          b_from_rin,
  input  logic          vec_valid,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rin,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_row,
  input  logic [AW-1:0] coef_col,
  input  logic [CW-1:0] coef_data,
  output logic          busy,
  output logic          res_valid,
  output logic [AW-1:0] res_index,
  output logic [OW-1:0] res_a,
  output logic [OW-1:0] res_b
);
  function automatic logic [OW-1:0] clip_out(input logic signed [ACCW-1:0] s);
    return s[OW-1:0];
  endfunction

  logic                      vec_accept;
  logic [AW-1:0]             wr_idx;
  logic                      dual_eff;
  logic                      bsel_eff;
  logic [AW-1:0]             bank;
  logic                      run_step;
  logic [NMAX-1:0][CW-1:0]   tap_coef;
  logic [NMAX-1:0][DW-1:0]   vec;
  logic signed [ACCW-1:0]    sum_lo;
  logic signed [ACCW-1:0]    sum_hi;
  logic signed [ACCW-1:0]    sum_all;

  mvm_seq #(.NMAX(NMAX)) i_seq (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .dual_mode(dual_mode),
    .b_from_rin(b_from_rin), .busy(busy), .vec_accept(vec_accept),
    .wr_idx(wr_idx), .dual_eff(dual_eff), .bsel_eff(bsel_eff), .bank(bank),
    .run_step(run_step)
  );

  mvm_coef_bank #(.NMAX(NMAX), .CW(CW)) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_row(coef_row),
    .wr_col(coef_col), .wr_data(coef_data), .bank(bank), .dual(dual_eff),
    .tap_coef(tap_coef)
  );

  mvm_tap_array #(.NMAX(NMAX), .CW(CW), .DW(DW)) i_taps (
    .tap_coef(tap_coef), .tap_data(vec), .sum_lo(sum_lo), .sum_hi(sum_hi)
  );

  assign sum_all = sum_lo + sum_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec <= '0;
    end else if (vec_accept) begin
      if (dual_eff) begin
        vec[wr_idx]                <= din;
        vec[AW'(NHALF) + wr_idx]   <= bsel_eff ? rin : din;
      end else begin
        vec[wr_idx] <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_index <= '0;
      res_a     <= '0;
      res_b     <= '0;
    end else begin
      res_valid <= run_step;
      if (run_step) begin
        res_index <= bank;
        if (dual_eff) begin
          res_a <= clip_out(sum_lo);
          res_b <= clip_out(sum_hi);
        end else begin
          res_a <= clip_out(sum_all);
          res_b <= '0;
        end
      end
    end
  end

  AST_FIRST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> res_valid && (res_index == '0)); // R2
  AST_RESULT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_index != '0) |-> $past(res_valid) && (res_index == $past(res_index) + 1'b1)); // R2
  AST_LAST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vec_valid) |=> $stable(vec)); // R6
  AST_SINGLE_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_step && !dual_eff) |=> (res_b == '0)); // R7
endmodule

// File: tb/test_mvm_engine.sv
`timescale 1ns/1ps
module test_mvm_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dual_mode = 1'b0, b_from_rin = 1'b0, vec_valid = 1'b0;
  logic [11:0] din = '0, rin = '0;
  logic        coef_we = 1'b0;
  logic [3:0]  coef_row = '0, coef_col = '0;
  logic [11:0] coef_data = '0;
  logic        busy, res_valid;
  logic [3:0]  res_index;
  logic [15:0] res_a, res_b;

  int checks = 0, failures = 0;
  int cm [16][16];
  int da [16];
  int rb [16];

  always #2.5 clk = ~clk;

  mvm_engine i_mvm_engine (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .b_from_rin(b_from_rin),
    .vec_valid(vec_valid), .din(din), .rin(rin), .coef_we(coef_we),
    .coef_row(coef_row), .coef_col(coef_col), .coef_data(coef_data),
    .busy(busy), .res_valid(res_valid), .res_index(res_index),
    .res_a(res_a), .res_b(res_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_coef(input int r, input int c, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_row = 4'(r); coef_col = 4'(c); coef_data = 12'(v);
    cm[r][c] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // Drives one vector and compares every output cycle with the model.
  task automatic run_vec(input bit dual, input bit bsel, input int gap,
                         input bit flip, input bit junk, input string req);
    int n;
    int ea, eb;
    n = dual ? 8 : 16;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din = 12'(da[i]); rin = 12'(rb[i]); vec_valid = 1'b1;
      dual_mode  = (i == 0 || !flip) ? dual : !dual;
      b_from_rin = (i == 0 || !flip) ? bsel : !bsel;
      for (int g = 0; g < gap && i < n - 1; g++) begin
        @(negedge clk);
        vec_valid = 1'b0; din = 12'h5A5; rin = 12'hA5A;
      end
    end
    @(negedge clk);
    vec_valid = junk; din = 12'h7FF; rin = 12'h800;
    check(busy == 1'b1, "R6 busy after last element", int'(busy), 1);
    check(res_valid == 1'b0, "R2 no result yet", int'(res_valid), 0);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (j == n - 1) vec_valid = 1'b0;
      ea = 0; eb = 0;
      for (int k = 0; k < n; k++) begin
        if (dual) begin
          ea += cm[j][k] * da[k];
          eb += cm[8 + j][8 + k] * (bsel ? rb[k] : da[k]);
        end else begin
          ea += cm[j][k] * da[k];
        end
      end
      check(res_valid == 1'b1, {req, " res_valid"}, int'(res_valid), 1);
      check(res_index == 4'(j), {req, " res_index"}, int'(res_index), j);
      check(res_a == 16'(ea), {req, " res_a"}, int'(res_a), int'(16'(ea)));
      if (dual) check(res_b == 16'(eb), {req, " res_b"}, int'(res_b), int'(16'(eb)));
      else      check(res_b == 16'd0, "R7 res_b zero in single", int'(res_b), 0);
      check(busy == (j != n - 1), "R6 busy during results", int'(busy), int'(j != n - 1));
    end
    @(negedge clk);
    check(res_valid == 1'b0, "R6 results end", int'(res_valid), 0);
    check(busy == 1'b0, "R6 idle after run", int'(busy), 0);
  endtask

  function automatic void fill(input int seed, input int lo_ext);
    for (int i = 0; i < 16; i++) begin
      da[i] = ((i * 733 + seed * 97) % 4096) - 2048;
      rb[i] = ((i * 419 + seed * 53 + 11) % 4096) - 2048;
      if (lo_ext == 1) begin da[i] = 2047; rb[i] = -2048; end
      if (lo_ext == 2) begin da[i] = -2048; rb[i] = 2047; end
    end
  endfunction

  initial begin
    #(5.0 * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && res_valid == 1'b0, "R1 reset flags", int'({busy, res_valid}), 0);
    check(res_a == 16'd0 && res_b == 16'd0, "R1 reset results", int'(res_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && res_valid == 1'b0, "R1 after release", int'({busy, res_valid}), 0);

    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        wr_coef(r, c, ((r * 37 + c * 11 + r * c * 5) % 4096) - 2048);

    fill(1, 0); run_vec(1'b0, 1'b0, 0, 1'b0, 1'b0, "R2 single");
    fill(2, 0); run_vec(1'b1, 1'b1, 0, 1'b0, 1'b0, "R3 R4 dual rin");
    fill(3, 0); run_vec(1'b1, 1'b0, 0, 1'b0, 1'b0, "R4 dual din");
    fill(4, 0); run_vec(1'b1, 1'b1, 2, 1'b0, 1'b1, "R10 R6 gaps and busy junk");
    fill(5, 0); run_vec(1'b0, 1'b0, 1, 1'b0, 1'b1, "R6 single busy junk");
    fill(6, 0); run_vec(1'b1, 1'b1, 0, 1'b1, 1'b0, "R8 dual then flip");
    fill(7, 0); run_vec(1'b0, 1'b0, 0, 1'b1, 1'b0, "R8 single then flip");

    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        if (((r + c) % 2) == 0) wr_coef(r, c, 2047);
        else                    wr_coef(r, c, -2048);
      end
    fill(0, 1); run_vec(1'b0, 1'b0, 0, 1'b0, 1'b0, "R5 single extremes");
    fill(0, 2); run_vec(1'b1, 1'b1, 0, 1'b0, 1'b0, "R5 dual extremes");

    wr_coef(3, 5, 1234);
    wr_coef(11, 9, -777);
    fill(8, 0); run_vec(1'b0, 1'b0, 0, 1'b0, 1'b0, "R9 overwrite single");
    fill(9, 0); run_vec(1'b1, 1'b0, 0, 1'b0, 1'b0, "R9 overwrite dual");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule